// File: doc/BRIEF.md
# Dual-Direction Latching Bus Transceiver

This block is a synchronous data-path stage between two buses, called A and B. Each direction has its own storage. A-to-B carries `a_in` to `b_out`, and B-to-A carries `b_in` to `a_out`. In each direction, a pass control and a capture strobe decide whether the storage follows its input bus, keeps its contents, or loads on a strobe edge. A separate drive control in each direction produces a drive-enable output. The A-to-B drive control is active high and the B-to-A drive control is active low. The drive-enable outputs are kept apart from the data outputs, so the surrounding logic builds any tri-state or mux itself.

The data path is divided into `N_HALF` slices of `HALF_W` bits each. By default that is two 18-bit halves. In split mode every half uses its own control bits. When `join_mode` is high, the controls of half 0 drive every half, so the block acts as one wide 36-bit channel. All controls are sampled on the free-running `clk`. Data and drive outputs come from registers, so they reflect what was sampled at the previous rising edge.

Each half and direction has a strobe tracker with two states. `TRK_LOW` means the strobe was last sampled low, and `TRK_HIGH` means it was last sampled high. The `RISE` transition goes from `TRK_LOW` to `TRK_HIGH` and the `FALL` transition goes back. A capture happens only on `RISE`. Reset places the tracker in `TRK_HIGH`.

Top module: `bus_xcvr_dual`

## Requirements
- R1: All controls and data are sampled at the rising edge of `clk`. Each data and drive output changes only on that edge, one cycle after the sample that caused the change.
- R2: While a half's effective pass control is 1, its stored value is reloaded from the source bus slice on every edge. The output therefore equals the input that was sampled one cycle earlier.
- R3: When the pass control is 0 and no strobe rising edge is sampled, the stored value does not change. This includes the cycle in which the pass control falls while the strobe is held at 1.
- R4: When the pass control is 0 and the strobe is sampled at 1 after being sampled at 0 on the previous edge, the current input slice is loaded into storage.
- R5: `b_drv[h]` equals the value of the effective A-to-B drive control sampled at the previous edge. That control is active high.
- R6: `a_drv[h]` is 1 exactly when the effective B-to-A drive control was sampled at 0 on the previous edge. That control is active low.
- R7: B-to-A storage loads from `b_in` under its own pass control and strobe, independently of the A-to-B direction.
- R8: With `join_mode` = 0, half `h` uses control bit `h` and data bits `[h*HALF_W +: HALF_W]`.
- R9: With `join_mode` = 1, the control bits at index 0 govern every half, and control bits at other indices have no effect.
- R10: While the synchronous active-low `rst_n` is 0, all storage clears to zero and all drive outputs go to 0. A strobe already at 1 in the first cycle after reset is not a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| join_mode | input | 1 | 1: half 0 controls govern all halves |
| a_in | input | HALF_W*N_HALF | A bus data in |
| b_in | input | HALF_W*N_HALF | B bus data in |
| ab_oe | input | N_HALF | A-to-B drive control, active high |
| ab_le | input | N_HALF | A-to-B pass control |
| ab_stb | input | N_HALF | A-to-B capture strobe |
| ba_oe_n | input | N_HALF | B-to-A drive control, active low |
| ba_le | input | N_HALF | B-to-A pass control |
| ba_stb | input | N_HALF | B-to-A capture strobe |
| b_out | output | HALF_W*N_HALF | Data toward B bus |
| b_drv | output | N_HALF | B drive enable per half |
| a_out | output | HALF_W*N_HALF | Data toward A bus |
| a_drv | output | N_HALF | A drive enable per half |

## Verification
On every cycle, the assertions check the following for half 0 and for the joined upper half:
- the one-cycle follow in pass mode,
- capture on a strobe rise,
- holding when neither pass nor capture applies,
- the polarity and delay of both drive enables,
- the cleared state under reset.

Some behaviours appear only in the bench scenarios. These are the independence of split halves, the suppression of upper-half controls in joined mode, and the absence of a capture when the strobe stays high through reset release. The bench compares every output of every half with its own reference model, using random control mixes and directed sequences.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;
    typedef enum logic {
        TRK_LOW  = 1'b0,
        TRK_HIGH = 1'b1
    } trk_state_e;
endpackage

// File: rtl/bus_xcvr_strobe_fsm.sv
module bus_xcvr_strobe_fsm
    import bus_xcvr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pass_en,
    input  logic strobe,
    output logic load
);
    trk_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_LOW:  if (strobe)  state_d = TRK_HIGH;  // RISE
            TRK_HIGH: if (!strobe) state_d = TRK_LOW;   // FALL
            default:  state_d = TRK_HIGH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TRK_HIGH;
        else        state_q <= state_d;
    end

    always_comb begin
        load = 1'b0;
        unique case (state_q)
            TRK_LOW:  load = pass_en | strobe;
            TRK_HIGH: load = pass_en;
            default:  load = pass_en;
        endcase
    end
endmodule

// File: rtl/bus_xcvr_lane.sv
module bus_xcvr_lane #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         drive_req,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         drive
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout  <= '0;
            drive <= 1'b0;
        end else begin
            if (load) dout <= din;
            drive <= drive_req;
        end
    end
endmodule

// File: rtl/bus_xcvr_dual.sv
module bus_xcvr_dual #(
    parameter int HALF_W = 18,
    parameter int N_HALF = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       join_mode,
    input  logic [HALF_W*N_HALF-1:0]   a_in,
    input  logic [HALF_W*N_HALF-1:0]   b_in,
    input  logic [N_HALF-1:0]          ab_oe,
    input  logic [N_HALF-1:0]          ab_le,
    input  logic [N_HALF-1:0]          ab_stb,
    input  logic [N_HALF-1:0]          ba_oe_n,
    input  logic [N_HALF-1:0]          ba_le,
    input  logic [N_HALF-1:0]          ba_stb,
    output logic [HALF_W*N_HALF-1:0]   b_out,
    output logic [N_HALF-1:0]          b_drv,
    output logic [HALF_W*N_HALF-1:0]   a_out,
    output logic [N_HALF-1:0]          a_drv
);
    logic [N_HALF-1:0] ab_oe_e, ab_le_e, ab_stb_e;
    logic [N_HALF-1:0] ba_oe_e, ba_le_e, ba_stb_e;
    logic [N_HALF-1:0] ab_load, ba_load;

    // R8 / R9: pick each half's control source
    always_comb begin
        for (int h = 0; h < N_HALF; h++) begin
            int src;
            src = join_mode ? 0 : h;
            ab_oe_e[h]  = ab_oe[src];
            ab_le_e[h]  = ab_le[src];
            ab_stb_e[h] = ab_stb[src];
            ba_oe_e[h]  = ~ba_oe_n[src];
            ba_le_e[h]  = ba_le[src];
            ba_stb_e[h] = ba_stb[src];
        end
    end

    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        bus_xcvr_strobe_fsm u_trk_ab (
            .clk(clk), .rst_n(rst_n), .pass_en(ab_le_e[h]),
            .strobe(ab_stb_e[h]), .load(ab_load[h])
        );
        bus_xcvr_strobe_fsm u_trk_ba (
            .clk(clk), .rst_n(rst_n), .pass_en(ba_le_e[h]),
            .strobe(ba_stb_e[h]), .load(ba_load[h])
        );
        bus_xcvr_lane #(.W(HALF_W)) u_lane_ab (
            .clk(clk), .rst_n(rst_n), .load(ab_load[h]),
            .drive_req(ab_oe_e[h]),
            .din(a_in[h*HALF_W +: HALF_W]),
            .dout(b_out[h*HALF_W +: HALF_W]),
            .drive(b_drv[h])
        );
        bus_xcvr_lane #(.W(HALF_W)) u_lane_ba (
            .clk(clk), .rst_n(rst_n), .load(ba_load[h]),
            .drive_req(ba_oe_e[h]),
            .din(b_in[h*HALF_W +: HALF_W]),
            .dout(a_out[h*HALF_W +: HALF_W]),
            .drive(a_drv[h])
        );
    end
endmodule

// File: rtl/bus_xcvr_dual_chk.sv
module bus_xcvr_dual_chk #(
    parameter int HALF_W = 18,
    parameter int N_HALF = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     join_mode,
    input logic [HALF_W*N_HALF-1:0] a_in,
    input logic [HALF_W*N_HALF-1:0] b_in,
    input logic [N_HALF-1:0]        ab_oe,
    input logic [N_HALF-1:0]        ab_le,
    input logic [N_HALF-1:0]        ab_stb,
    input logic [N_HALF-1:0]        ba_oe_n,
    input logic [N_HALF-1:0]        ba_le,
    input logic [N_HALF-1:0]        ba_stb,
    input logic [HALF_W*N_HALF-1:0] b_out,
    input logic [N_HALF-1:0]        b_drv,
    input logic [HALF_W*N_HALF-1:0] a_out,
    input logic [N_HALF-1:0]        a_drv
);
    localparam int BUS_W = HALF_W * N_HALF;

    AST_AB_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ab_le[0] |=> b_out[HALF_W-1:0] == $past(a_in[HALF_W-1:0]));  // R2
    AST_BA_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ba_le[0] |=> a_out[HALF_W-1:0] == $past(b_in[HALF_W-1:0]));  // R7
    AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !ab_le[0] && !(ab_stb[0] && !$past(ab_stb[0])))
        |=> $stable(b_out[HALF_W-1:0]));  // R3
    AST_AB_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !ab_le[0] && ab_stb[0] && !$past(ab_stb[0]))
        |=> b_out[HALF_W-1:0] == $past(a_in[HALF_W-1:0]));  // R4
    AST_B_DRV_ON: assert property (@(posedge clk) disable iff (!rst_n)
        ab_oe[0] |=> b_drv[0]);  // R5
    AST_B_DRV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !ab_oe[0] |=> !b_drv[0]);  // R5
    AST_A_DRV_ON: assert property (@(posedge clk) disable iff (!rst_n)
        !ba_oe_n[0] |=> a_drv[0]);  // R6
    AST_A_DRV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ba_oe_n[0] |=> !a_drv[0]);  // R6
    AST_JOIN_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (join_mode && ab_le[0])
        |=> b_out[BUS_W-1 -: HALF_W] == $past(a_in[BUS_W-1 -: HALF_W]));  // R9
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (b_out == '0 && a_out == '0 && b_drv == '0 && a_drv == '0));  // R10
endmodule

bind bus_xcvr_dual bus_xcvr_dual_chk #(.HALF_W(HALF_W), .N_HALF(N_HALF)) u_chk (
    .clk(clk), .rst_n(rst_n), .join_mode(join_mode), .a_in(a_in), .b_in(b_in),
    .ab_oe(ab_oe), .ab_le(ab_le), .ab_stb(ab_stb),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_stb(ba_stb),
    .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv)
);

// File: tb/bus_xcvr_dual_tb.sv
module bus_xcvr_dual_tb;
    localparam int HW = 18;
    localparam int NH = 2;
    localparam int BW = HW * NH;

    logic clk = 1'b0;
    logic rst_n;
    logic join_mode;
    logic [BW-1:0] a_in, b_in, b_out, a_out;
    logic [NH-1:0] ab_oe, ab_le, ab_stb, ba_oe_n, ba_le, ba_stb, b_drv, a_drv;

    always #4 clk = ~clk;

    bus_xcvr_dual #(.HALF_W(HW), .N_HALF(NH)) u_dut (
        .clk(clk), .rst_n(rst_n), .join_mode(join_mode), .a_in(a_in), .b_in(b_in),
        .ab_oe(ab_oe), .ab_le(ab_le), .ab_stb(ab_stb),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_stb(ba_stb),
        .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv)
    );

    int total = 0;
    int bad = 0;
    logic [HW-1:0] m_b [NH];
    logic [HW-1:0] m_a [NH];
    logic m_bd [NH];
    logic m_ad [NH];
    logic m_abp [NH];
    logic m_bap [NH];
    string tag_b [NH];
    string tag_a [NH];

    task automatic chk(string req, logic [HW-1:0] act, logic [HW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string mode_tag(logic le, logic edge_seen);
        if (le) return "R2";
        if (edge_seen) return "R4";
        return "R3";
    endfunction

    task automatic model_edge();
        for (int h = 0; h < NH; h++) begin
            int c;
            logic eab, eba;
            c = join_mode ? 0 : h;
            if (!rst_n) begin
                m_b[h] = '0; m_a[h] = '0; m_bd[h] = 1'b0; m_ad[h] = 1'b0;
                m_abp[h] = 1'b1; m_bap[h] = 1'b1;
                tag_b[h] = "R10"; tag_a[h] = "R10";
            end else begin
                eab = ab_stb[c] && !m_abp[h];
                eba = ba_stb[c] && !m_bap[h];
                if (ab_le[c] || eab) m_b[h] = a_in[h*HW +: HW];
                if (ba_le[c] || eba) m_a[h] = b_in[h*HW +: HW];
                tag_b[h] = mode_tag(ab_le[c], eab);
                tag_a[h] = {"R7 ", mode_tag(ba_le[c], eba)};
                if (h > 0) begin
                    tag_b[h] = {tag_b[h], join_mode ? " R9" : " R8"};
                    tag_a[h] = {tag_a[h], join_mode ? " R9" : " R8"};
                end
                m_abp[h] = ab_stb[c];
                m_bap[h] = ba_stb[c];
                m_bd[h] = ab_oe[c];
                m_ad[h] = ~ba_oe_n[c];
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        for (int h = 0; h < NH; h++) begin
            chk({tag_b[h], " R1 b_out"}, b_out[h*HW +: HW], m_b[h]);
            chk({tag_a[h], " R1 a_out"}, a_out[h*HW +: HW], m_a[h]);
            chk(rst_n ? "R5 b_drv" : "R10 b_drv", {{(HW-1){1'b0}}, b_drv[h]}, {{(HW-1){1'b0}}, m_bd[h]});
            chk(rst_n ? "R6 a_drv" : "R10 a_drv", {{(HW-1){1'b0}}, a_drv[h]}, {{(HW-1){1'b0}}, m_ad[h]});
        end
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = 32'd1357;
        void'($urandom(seed));
        rst_n = 1'b0; join_mode = 1'b0;
        a_in = '0; b_in = '0;
        ab_oe = '0; ab_le = '0; ab_stb = '1;
        ba_oe_n = '1; ba_le = '0; ba_stb = '1;
        @(negedge clk);
        repeat (3) step();                       // R10 reset state
        rst_n = 1'b1;
        a_in = {BW{1'b1}}; b_in = {BW{1'b1}};
        step();                                  // R10 strobe already high: no capture
        // R2 follow, then R3 pass falls while strobe high
        ab_le = '1; ba_le = '1; ab_oe = '1; ba_oe_n = '0;
        a_in = 36'h1_2345_6789; b_in = 36'h9_8765_4321;
        step();
        ab_le = '0; ba_le = '0;
        a_in = 36'h0_0000_0abc; b_in = 36'h0_0000_0def;
        repeat (2) step();
        // R4 strobe low then high
        ab_stb = '0; ba_stb = '0; step();
        ab_stb = '1; ba_stb = '1; a_in = 36'h5_5555_5555; b_in = 36'hA_AAAA_AAAA; step();
        a_in = '0; b_in = '0; step();            // R3 steady high
        // R9 joined: half 1 controls contradict half 0
        join_mode = 1'b1;
        ab_le = 2'b01; ba_le = 2'b10; ab_oe = 2'b01; ba_oe_n = 2'b01;
        a_in = 36'h3_C3C3_C3C3; b_in = 36'h6_1111_2222;
        repeat (2) step();
        // random mix in both modes
        for (int i = 0; i < 4000; i++) begin
            if (i % 500 == 0) join_mode = $urandom_range(0, 1);
            rst_n = ($urandom_range(0, 199) != 0);
            a_in = {$urandom(), $urandom()};
            b_in = {$urandom(), $urandom()};
            ab_oe = $urandom(); ba_oe_n = $urandom();
            for (int h = 0; h < NH; h++) begin
                ab_le[h] = ($urandom_range(0, 3) == 0);
                ba_le[h] = ($urandom_range(0, 3) == 0);
            end
            ab_stb = $urandom(); ba_stb = $urandom();
            step();
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule